// File: doc/BRIEF.md
# Dual-Set Pattern Bank Mapper

This block translates a 13-bit video pattern-table address (range $0000-$1FFF) into a 20-bit physical pattern ROM address, which covers up to 1 MB. The CPU programs the block through a small register port. There is a page-size mode register, a sprite set of eight bank registers, a background set of four bank registers, and a 2-bit high-bits register. Each bank register holds a 10-bit bank number. The high-bits register supplies the top two bits of that number at the moment the bank register is written.

The block has two register sets, and the mapping uses only one of them for each fetch. When tall (8x16) sprites are on, the fetch type decides: sprite fetches use the sprite set and background fetches use the background set. When tall sprites are off, every fetch uses the set that the CPU wrote most recently. The background set describes only the lower 4 KB of pattern space, and the upper 4 KB repeats that same mapping. The output is combinational from the video address and the registered configuration.

Top module: `chr_bank_mapper`

## Requirements
- R1: After a synchronous reset, every bank register, the mode and the high bits are zero, and the most recently written set is the sprite set, so `pat_addr` equals `vid_addr` zero-extended.
- R2: A write with `cfg_we`=1 is decoded by `cfg_sel`. Codes 0-7 select sprite bank registers 0-7, codes 8-11 select background bank registers 0-3, code 12 loads the mode from `cfg_data[1:0]`, and code 13 loads the high bits from `cfg_data[1:0]`. Codes 14 and 15 have no effect.
- R3: The mode selects the page size: 0 gives 8 KB, 1 gives 4 KB, 2 gives 2 KB and 3 gives 1 KB. The output is (bank << (13 - mode)) plus the in-page offset `vid_addr` mod 2^(13-mode), and the video address bits below the page size pass through unchanged.
- R4: For the sprite set, with slice = `vid_addr[12:10]`: mode 3 uses register slice, mode 2 uses register (slice | 1), mode 1 uses register 3 for the lower half and register 7 for the upper half, and mode 0 uses register 7.
- R5: For the background set, with s = `vid_addr[11:10]`: mode 3 uses register s, mode 2 uses register (s | 1), and modes 1 and 0 use register 3. `vid_addr[12]` does not change which register is chosen.
- R6: With `tall_spr`=1, a fetch that has `fetch_is_spr`=1 uses the sprite set and a fetch that has `fetch_is_spr`=0 uses the background set, whichever set was written last.
- R7: With `tall_spr`=0, all fetches use the set that received the latest bank register write (codes 0-7 mean sprite, codes 8-11 mean background). `fetch_is_spr` is then ignored.
- R8: A bank register stores the high bits as they are at its write. A later change of the high bits does not alter banks that were already written.
- R9: The physical address is kept to its low 20 bits, so bank bits that would address beyond 1 MB are dropped.
- R10: Writes to the mode register, the high-bits register or the unused codes do not change which set was written last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select code |
| cfg_data | input | 8 | Register write data |
| vid_addr | input | 13 | Video pattern-table address |
| tall_spr | input | 1 | Tall (8x16) sprites enabled |
| fetch_is_spr | input | 1 | Current fetch is a sprite fetch |
| pat_addr | output | 20 | Physical pattern ROM address |

## Verification
A wrong internal state has two possible effects. A wrong bank value or a stale high-bits capture sends `pat_addr` to another page. A wrong last-written-set flag makes fetches read from the wrong set. The output is combinational from the registers, so either fault shows up in the first fetch after the faulty write that lands in an affected slice. The bench compares every cycle against a reference model while the address sweeps over all slices. The flag fault shows only when the two sets hold different banks and tall sprites are off, so the stimulus keeps the two sets distinct and switches tall mode often.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

    localparam int SPR_REGS = 8;
    localparam int BG_REGS  = 4;
    localparam int DATA_W   = 8;
    localparam int HI_W     = 2;
    localparam int BANK_W   = DATA_W + HI_W;
    localparam int VADDR_W  = 13;
    localparam int PADDR_W  = 20;
    localparam int SEL_W    = 4;
    localparam int SLICE_W  = $clog2(SPR_REGS);
    localparam int SPR_IW   = $clog2(SPR_REGS);
    localparam int BG_IW    = $clog2(BG_REGS);

    localparam logic [SEL_W-1:0] SEL_MODE = 4'd12;
    localparam logic [SEL_W-1:0] SEL_HI   = 4'd13;

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        PG_8K = 2'd0,
        PG_4K = 2'd1,
        PG_2K = 2'd2,
        PG_1K = 2'd3
    } page_mode_t;

    typedef enum logic {
        SET_SPR = 1'b0,
        SET_BG  = 1'b1
    } bank_set_t;

    typedef struct packed {
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } cfg_wr_t;

    // Register of the sprite set that serves a given 1 KB slice.
    function automatic logic [SPR_IW-1:0] spr_slot(page_mode_t m, logic [SLICE_W-1:0] slice);
        case (m)
            PG_1K:   return slice;
            PG_2K:   return slice | SPR_IW'(1);
            PG_4K:   return {slice[SLICE_W-1], {(SPR_IW-1){1'b1}}};
            default: return SPR_IW'(SPR_REGS - 1);
        endcase
    endfunction

    // Register of the background set; upper half mirrors the lower half.
    function automatic logic [BG_IW-1:0] bg_slot(page_mode_t m, logic [SLICE_W-1:0] slice);
        logic [BG_IW-1:0] s;
        s = slice[BG_IW-1:0];
        case (m)
            PG_1K:   return s;
            PG_2K:   return s | BG_IW'(1);
            default: return BG_IW'(BG_REGS - 1);
        endcase
    endfunction

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import chr_map_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  cfg_wr_t                  wr,
    output bank_t [SPR_REGS-1:0]     spr_banks,
    output bank_t [BG_REGS-1:0]      bg_banks,
    output page_mode_t               mode,
    output bank_set_t                last_set
);

    logic [HI_W-1:0] hi_q;
    logic            wr_spr;
    logic            wr_bg;

    assign wr_spr = wr.we && (wr.sel < SEL_W'(SPR_REGS));
    assign wr_bg  = wr.we && (wr.sel >= SEL_W'(SPR_REGS)) && (wr.sel < SEL_W'(SPR_REGS + BG_REGS));

    generate
        for (genvar i = 0; i < SPR_REGS; i++) begin : g_spr
            always_ff @(posedge clk) begin
                if (rst)
                    spr_banks[i] <= '0;
                else if (wr.we && wr.sel == SEL_W'(i))
                    spr_banks[i] <= {hi_q, wr.data};
            end
            // R8
            spr_store_chk: assert property (@(posedge clk) disable iff (rst)
                (wr.we && wr.sel == SEL_W'(i)) |=> spr_banks[i] == {$past(hi_q), $past(wr.data)});
        end
        for (genvar j = 0; j < BG_REGS; j++) begin : g_bg
            always_ff @(posedge clk) begin
                if (rst)
                    bg_banks[j] <= '0;
                else if (wr.we && wr.sel == SEL_W'(SPR_REGS + j))
                    bg_banks[j] <= {hi_q, wr.data};
            end
            // R8
            bg_store_chk: assert property (@(posedge clk) disable iff (rst)
                (wr.we && wr.sel == SEL_W'(SPR_REGS + j)) |=> bg_banks[j] == {$past(hi_q), $past(wr.data)});
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            mode     <= PG_8K;
            last_set <= SET_SPR;
        end else begin
            if (wr.we && wr.sel == SEL_MODE)
                mode <= page_mode_t'(wr.data[1:0]);
            if (wr.we && wr.sel == SEL_HI)
                hi_q <= wr.data[HI_W-1:0];
            if (wr_spr)
                last_set <= SET_SPR;
            else if (wr_bg)
                last_set <= SET_BG;
        end
    end

    // R7
    spr_last_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.sel < SEL_W'(SPR_REGS)) |=> last_set == SET_SPR);

    // R7
    bg_last_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.sel[SEL_W-1 -: 2] == 2'b10) |=> last_set == SET_BG);

    // R10
    cfg_keeps_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr.we || wr.sel >= SEL_MODE) |=> $stable(last_set));

endmodule

// File: rtl/chr_slot_pick.sv
module chr_slot_pick
    import chr_map_pkg::*;
(
    input  page_mode_t               mode,
    input  logic [SLICE_W-1:0]       slice,
    input  logic                     use_bg,
    input  bank_t [SPR_REGS-1:0]     spr_banks,
    input  bank_t [BG_REGS-1:0]      bg_banks,
    output bank_t                    bank
);

    logic [SPR_IW-1:0] spr_idx;
    logic [BG_IW-1:0]  bg_idx;

    always_comb begin
        spr_idx = spr_slot(mode, slice);
        bg_idx  = bg_slot(mode, slice);
        bank    = use_bg ? bg_banks[bg_idx] : spr_banks[spr_idx];
    end

endmodule

// File: rtl/chr_addr_form.sv
module chr_addr_form
    import chr_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  page_mode_t         mode,
    input  bank_t              bank,
    input  logic [VADDR_W-1:0] vaddr,
    output logic [PADDR_W-1:0] paddr
);

    localparam int WIDE_W = BANK_W + VADDR_W;

    logic [VADDR_W-1:0] off_mask;
    logic [WIDE_W-1:0]  wide;

    always_comb begin
        off_mask = {VADDR_W{1'b1}} >> mode;
        wide     = ({bank, {VADDR_W{1'b0}}} >> mode) | {{BANK_W{1'b0}}, vaddr & off_mask};
        paddr    = wide[PADDR_W-1:0];
    end

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        paddr[VADDR_W-4:0] == vaddr[VADDR_W-4:0]);

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
    import chr_map_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [DATA_W-1:0]   cfg_data,
    input  logic [VADDR_W-1:0]  vid_addr,
    input  logic                tall_spr,
    input  logic                fetch_is_spr,
    output logic [PADDR_W-1:0]  pat_addr
);

    cfg_wr_t               wr;
    bank_t [SPR_REGS-1:0]  spr_banks;
    bank_t [BG_REGS-1:0]   bg_banks;
    page_mode_t            mode;
    bank_set_t             last_set;
    logic                  use_bg;
    bank_t                 bank;

    assign wr = '{we: cfg_we, sel: cfg_sel, data: cfg_data};

    chr_bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .spr_banks (spr_banks),
        .bg_banks  (bg_banks),
        .mode      (mode),
        .last_set  (last_set)
    );

    assign use_bg = tall_spr ? !fetch_is_spr : (last_set == SET_BG);

    chr_slot_pick u_pick (
        .mode      (mode),
        .slice     (vid_addr[VADDR_W-1 -: SLICE_W]),
        .use_bg    (use_bg),
        .spr_banks (spr_banks),
        .bg_banks  (bg_banks),
        .bank      (bank)
    );

    chr_addr_form u_form (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .bank  (bank),
        .vaddr (vid_addr),
        .paddr (pat_addr)
    );

    // R6
    tall_spr_path_chk: assert property (@(posedge clk) disable iff (rst)
        (tall_spr && fetch_is_spr && mode == PG_8K) |-> bank == spr_banks[SPR_REGS-1]);

    // R6
    tall_bg_path_chk: assert property (@(posedge clk) disable iff (rst)
        (tall_spr && !fetch_is_spr && mode == PG_8K) |-> bank == bg_banks[BG_REGS-1]);

endmodule

// File: tb/sim_chr_bank_mapper.sv
module sim_chr_bank_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic [12:0] vid_addr = '0;
    logic        tall_spr = 1'b0;
    logic        fetch_is_spr = 1'b0;
    logic [19:0] pat_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_spr[8];
    int m_bg[4];
    int m_mode = 0;
    int m_hi = 0;
    int m_lastbg = 0;

    always #2.5 clk = ~clk;

    chr_bank_mapper u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .vid_addr(vid_addr), .tall_spr(tall_spr), .fetch_is_spr(fetch_is_spr), .pat_addr(pat_addr)
    );

    function automatic void model_reset();
        foreach (m_spr[i]) m_spr[i] = 0;
        foreach (m_bg[i]) m_bg[i] = 0;
        m_mode = 0; m_hi = 0; m_lastbg = 0;
    endfunction

    function automatic void model_write(int sel, int d);
        if (sel < 8) begin
            m_spr[sel] = m_hi * 256 + d; m_lastbg = 0;
        end else if (sel < 12) begin
            m_bg[sel - 8] = m_hi * 256 + d; m_lastbg = 1;
        end else if (sel == 12) m_mode = d % 4;
        else if (sel == 13) m_hi = d % 4;
    endfunction

    function automatic int model_out(int a, int t, int fs);
        int use_bg, slice, idx, bank, sh;
        use_bg = t ? !fs : m_lastbg;
        slice = a / 1024;
        if (!use_bg) begin
            if (m_mode == 3) idx = slice;
            else if (m_mode == 2) idx = slice | 1;
            else if (m_mode == 1) idx = (slice & 4) | 3;
            else idx = 7;
            bank = m_spr[idx];
        end else begin
            slice = slice & 3;
            if (m_mode == 3) idx = slice;
            else if (m_mode == 2) idx = slice | 1;
            else idx = 3;
            bank = m_bg[idx];
        end
        sh = 13 - m_mode;
        return ((bank << sh) | (a & ((1 << sh) - 1))) & 32'hFFFFF;
    endfunction

    task automatic step(input bit we, input int sel, input int d, input int a,
                        input bit t, input bit fs, input string tag);
        int exp;
        cfg_we = we; cfg_sel = 4'(sel); cfg_data = 8'(d);
        vid_addr = 13'(a); tall_spr = t; fetch_is_spr = fs;
        @(negedge clk);
        if (we) model_write(sel, d);
        exp = model_out(a, t, fs);
        total++;
        if (pat_addr !== 20'(exp)) begin
            bad++;
            $display("FAIL %s: addr=%h tall=%0b spr=%0b got=%h exp=%h",
                     tag, a, t, fs, pat_addr, 20'(exp));
        end
    endtask

    task automatic wr(input int sel, input int d, input string tag);
        step(1'b1, sel, d, 0, 1'b0, 1'b0, tag);
    endtask

    task automatic look(input int a, input bit t, input bit fs, input string tag);
        step(1'b0, 0, 0, a, t, fs, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, output equals address
        look(13'h1ABC, 1'b0, 1'b0, "R1");
        look(13'h0123, 1'b1, 1'b0, "R1");

        // distinct banks in both sets
        for (int i = 0; i < 8; i++) wr(i, 16 + i * 3, "R2");
        for (int i = 0; i < 4; i++) wr(8 + i, 200 + i * 5, "R2");
        // R3/R4/R5: every mode, every slice, both sets via tall mode
        for (int m = 0; m < 4; m++) begin
            wr(12, m, "R3");
            for (int s = 0; s < 8; s++) begin
                look(s * 1024 + 37 * s + 5, 1'b1, 1'b1, "R4");
                look(s * 1024 + 91, 1'b1, 1'b0, "R5");
            end
        end
        // R7: last write decides; fetch_is_spr ignored
        wr(12, 3, "R3");
        wr(2, 77, "R7");
        look(13'h0800, 1'b0, 1'b0, "R7");
        wr(9, 55, "R7");
        look(13'h0400, 1'b0, 1'b1, "R7");
        look(13'h1400, 1'b0, 1'b1, "R5");
        // R6: tall mode overrides last written set
        look(13'h0400, 1'b1, 1'b1, "R6");
        look(13'h0400, 1'b1, 1'b0, "R6");
        // R10: mode, high bits and unused codes keep last set (background now)
        wr(12, 3, "R10");
        wr(13, 0, "R10");
        wr(14, 9, "R10");
        wr(15, 9, "R10");
        look(13'h0C00, 1'b0, 1'b1, "R10");
        // R2: unused codes leave banks alone
        look(13'h1C00, 1'b1, 1'b1, "R2");
        // R8: high bits captured at write time
        wr(13, 2, "R8");
        wr(5, 8'h44, "R8");
        wr(13, 1, "R8");
        look(13'h1400, 1'b0, 1'b0, "R8");
        wr(6, 8'h10, "R8");
        look(13'h1800, 1'b0, 1'b0, "R8");
        look(13'h1400, 1'b0, 1'b0, "R8");
        // R9: top bank bits dropped in large pages
        wr(13, 3, "R9");
        wr(7, 8'hFF, "R9");
        wr(12, 0, "R9");
        look(13'h1FFF, 1'b0, 1'b0, "R9");
        wr(12, 1, "R9");
        look(13'h1ABC, 1'b0, 1'b0, "R9");

        // random mixed traffic checked each clock
        for (int n = 0; n < 4000; n++) begin
            bit we;
            we = ($urandom % 4) == 0;
            step(we, $urandom % 16, $urandom % 256, $urandom % 8192,
                 1'(($urandom % 3) == 0), 1'($urandom % 2), "R3/R4/R5/R7");
        end

        // R1: reset again returns to pass-through
        rst = 1'b1; cfg_we = 1'b0;
        @(negedge clk);
        model_reset();
        rst = 1'b0;
        look(13'h1777, 1'b0, 1'b1, "R1");
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: got=hung exp=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule